// File: doc/BRIEF.md
# Weighted Trigger Primitive Filter

This block turns raw per-crossing energy samples from several readout channels into one coarse trigger-tower energy per crossing. On every clock, which is one 25 ns bunch crossing, it takes one sample from each channel and adds the channels of the tower. It keeps the tower sums of the most recent crossings and forms a signed weighted sum over a short window that is centred on the crossing expected to hold the pulse peak. The weights on the crossings before and after the peak are negative, so they cancel pile-up from neighbouring crossings.

The filtered value then goes through a noise cut and is reduced to 1 GeV units for the trigger. Two window shapes are selectable. The long window has eight taps and covers crossings −4 to +3 around the peak. The short window has five taps and covers crossings −3 to +1. The weights come in as signed fixed-point coefficients from configuration registers outside the block. Sample units are 1/16 GeV per LSB, so a noise cut of 100 MeV is a threshold of about 410 in the filter's fixed-point scale.

Top module: `trig_tower_filter`

## Requirements
- R1: The tower value for a crossing is the unsigned sum of all N_CH channel samples of that crossing. Channel c occupies bits [c*SAMP_W +: SAMP_W] of `chan_i`.
- R2: With `tap_mode_i` = 0 (long window), coefficient k (bits [k*COEF_W +: COEF_W] of `coef_i`, k = 0..7) multiplies the tower value from 7−k crossings before the newest one. Coefficient 0 therefore weights crossing −4 and coefficient 7 weights crossing +3.
- R3: With `tap_mode_i` = 1 (short window), coefficient k for k = 0..4 multiplies the tower value from 4−k crossings before the newest one. Coefficients 5..7 have no effect on the output.
- R4: Coefficients are two's-complement with 8 fractional bits. The weighted sum is exact, with no wrap, for any samples and coefficients, including all samples at full scale with extreme coefficients.
- R5: A negative weighted sum gives an output of 0.
- R6: A weighted sum below `thr_i` (same fixed-point scale, unsigned) gives an output of 0.
- R7: Otherwise the output is floor(sum / 2^12), which is 1 GeV units for 1/16 GeV samples with 8 fractional bits. It saturates at 255.
- R8: The result for a window whose newest sample is presented before clock edge j appears on the outputs just after edge j+2.
- R9: After reset the outputs are `tow_o` = 0 and `tow_valid_o` = 0. `tow_valid_o` rises only for windows in which every tap holds a sample taken since reset (8 samples in the long mode, 5 in the short mode). While `tow_valid_o` is 0, `tow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one sample set per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_i | input | N_CH*SAMP_W | Packed channel samples of the current crossing |
| tap_mode_i | input | 1 | 0 = eight-tap window, 1 = five-tap window |
| coef_i | input | N_TAP*COEF_W | Packed signed Q.8 tap weights |
| thr_i | input | ACC_W-1 | Noise cut on the weighted sum, Q.8 sample units |
| tow_o | output | OUT_W | Quantized tower energy in GeV |
| tow_valid_o | output | 1 | Window filled, output meaningful |

## Verification
The filter is driven with a single-channel impulse, a slow ramp, two scrambled sequences with different channel mixes, and all channels at full scale. Each pattern is run in both window modes. The impulse and a set of all-positive, distinct weights separate the taps from one another, so a swapped or shifted tap changes the result. The scrambled sequences with the nominal weights exercise negative sums and the clamp at zero. Full scale with the largest positive and negative weights shows that the accumulator does not wrap and that the output saturates. A raised threshold separates the noise cut from the quantizer's own truncation. In the short mode the three unused coefficients carry nonzero values that must not affect the output.

// File: rtl/ttf_pkg.sv
// Shared type for the tower filter: the window shape selector.
package ttf_pkg;
    typedef enum logic {
        MODE_8TAP = 1'b0,
        MODE_5TAP = 1'b1
    } tap_mode_e;
endpackage

// File: rtl/ttf_chan_sum.sv
// Channel adder: combinational sum of N_CH unsigned samples into one tower value.
// Assumes TOW_W is wide enough to hold N_CH full-scale samples.
module ttf_chan_sum #(
    parameter int N_CH   = 5,
    parameter int SAMP_W = 10,
    parameter int TOW_W  = 13
) (
    input  logic [N_CH*SAMP_W-1:0] chan_i,
    output logic [TOW_W-1:0]       tow_o
);
    // Zero-extend each channel and add.
    always_comb begin
        tow_o = '0;
        for (int c = 0; c < N_CH; c++) begin
            tow_o = tow_o + {{(TOW_W-SAMP_W){1'b0}}, chan_i[c*SAMP_W +: SAMP_W]};
        end
    end
endmodule

// File: rtl/ttf_window.sv
// Crossing history: shift register of tower values, newest in slot 0, plus a
// saturating fill count that reports when the selected window is fully loaded.
// Assumes one new tower value per clock.
module ttf_window
    import ttf_pkg::*;
#(
    parameter int N_TAP     = 8,
    parameter int N_TAP_ALT = 5,
    parameter int TOW_W     = 13,
    parameter int CNT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TOW_W-1:0]       tow_i,
    input  tap_mode_e              mode_i,
    output logic [N_TAP*TOW_W-1:0] win_o,
    output logic                   win_ok_o
);
    logic [TOW_W-1:0] win_q [N_TAP];
    logic [CNT_W-1:0] fill_q;

    // Shift history by one crossing and count samples up to the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TAP; i++) win_q[i] <= '0;
            fill_q <= '0;
        end else begin
            win_q[0] <= tow_i;
            for (int i = 1; i < N_TAP; i++) win_q[i] <= win_q[i-1];
            if (fill_q != CNT_W'(N_TAP)) fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar i = 0; i < N_TAP; i++) begin : g_flat
        assign win_o[i*TOW_W +: TOW_W] = win_q[i];
    end

    // Window usable once every tap of the selected shape holds a real sample.
    assign win_ok_o = (mode_i == MODE_5TAP) ? (fill_q >= CNT_W'(N_TAP_ALT))
                                            : (fill_q >= CNT_W'(N_TAP));
endmodule

// File: rtl/ttf_mac.sv
// Weighted sum: one multiplier per tap, sample selection chosen by the window
// shape, exact signed accumulation, result registered with its valid flag.
// Assumes ACC_W covers N_TAP worst-case products.
module ttf_mac
    import ttf_pkg::*;
#(
    parameter int N_TAP     = 8,
    parameter int N_TAP_ALT = 5,
    parameter int TOW_W     = 13,
    parameter int COEF_W    = 12,
    parameter int PROD_W    = 26,
    parameter int ACC_W     = 29
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_TAP*TOW_W-1:0]   win_i,
    input  logic [N_TAP*COEF_W-1:0]  coef_i,
    input  tap_mode_e                mode_i,
    input  logic                     win_ok_i,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic                     acc_v_o
);
    logic signed [PROD_W-1:0] prod [N_TAP];
    logic signed [ACC_W-1:0]  sum;

    for (genvar k = 0; k < N_TAP; k++) begin : g_tap
        logic [TOW_W-1:0]         s_long;
        logic [TOW_W-1:0]         s_short;
        logic [TOW_W-1:0]         s_sel;
        logic signed [COEF_W-1:0] cf;
        assign cf     = coef_i[k*COEF_W +: COEF_W];
        assign s_long = win_i[(N_TAP-1-k)*TOW_W +: TOW_W];
        if (k < N_TAP_ALT) begin : g_alt
            assign s_short = win_i[(N_TAP_ALT-1-k)*TOW_W +: TOW_W];
        end else begin : g_unused
            assign s_short = '0;
        end
        assign s_sel   = (mode_i == MODE_5TAP) ? s_short : s_long;
        assign prod[k] = $signed({1'b0, s_sel}) * cf;
    end

    // Sign-extend every product and add them.
    always_comb begin
        sum = '0;
        for (int k = 0; k < N_TAP; k++) sum = sum + ACC_W'(prod[k]);
    end

    // Register the sum and whether its window was full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o   <= '0;
            acc_v_o <= 1'b0;
        end else begin
            acc_o   <= sum;
            acc_v_o <= win_ok_i;
        end
    end
endmodule

// File: rtl/ttf_quant.sv
// Output stage: clamps negatives, applies the noise cut, drops SH fraction
// bits and saturates to OUT_W bits. Output held at zero while invalid.
module ttf_quant #(
    parameter int ACC_W = 29,
    parameter int SH    = 12,
    parameter int OUT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic                    acc_v_i,
    input  logic [ACC_W-2:0]        thr_i,
    output logic [OUT_W-1:0]        tow_o,
    output logic                    tow_valid_o
);
    localparam int unsigned MAXV = 2**OUT_W - 1;

    logic [ACC_W-1:0] shifted;
    logic [OUT_W-1:0] q;
    logic             cut;

    // Decide zeroing and compute the saturated coarse value.
    always_comb begin
        cut     = !acc_v_i || acc_i[ACC_W-1] || (acc_i < $signed({1'b0, thr_i}));
        shifted = acc_i[ACC_W-1:0] >> SH;
        if (cut)                           q = '0;
        else if (shifted > ACC_W'(MAXV))   q = OUT_W'(MAXV);
        else                               q = shifted[OUT_W-1:0];
    end

    // Register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tow_o       <= '0;
            tow_valid_o <= 1'b0;
        end else begin
            tow_o       <= q;
            tow_valid_o <= acc_v_i;
        end
    end
endmodule

// File: rtl/trig_tower_filter.sv
// Trigger-tower filter top: channel sum -> crossing history -> weighted sum
// -> noise cut and coarse quantization. Three register stages from sample
// to output. Assumes one sample set per clock and quasi-static configuration.
module trig_tower_filter
    import ttf_pkg::*;
#(
    parameter int N_CH      = 5,
    parameter int SAMP_W    = 10,
    parameter int N_TAP     = 8,
    parameter int N_TAP_ALT = 5,
    parameter int COEF_W    = 12,
    parameter int FRAC_W    = 8,
    parameter int QSH       = 4,
    parameter int OUT_W     = 8,
    localparam int TOW_W    = SAMP_W + $clog2(N_CH),
    localparam int PROD_W   = TOW_W + 1 + COEF_W,
    localparam int ACC_W    = PROD_W + $clog2(N_TAP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH*SAMP_W-1:0]  chan_i,
    input  logic                    tap_mode_i,
    input  logic [N_TAP*COEF_W-1:0] coef_i,
    input  logic [ACC_W-2:0]        thr_i,
    output logic [OUT_W-1:0]        tow_o,
    output logic                    tow_valid_o
);
    localparam int CNT_W = $clog2(N_TAP + 1);
    localparam int SH    = FRAC_W + QSH;

    tap_mode_e               mode;
    logic [TOW_W-1:0]        tow_sum;
    logic [N_TAP*TOW_W-1:0]  win;
    logic                    win_ok;
    logic signed [ACC_W-1:0] acc_q;
    logic                    acc_v_q;

    assign mode = tap_mode_e'(tap_mode_i);

    ttf_chan_sum #(.N_CH(N_CH), .SAMP_W(SAMP_W), .TOW_W(TOW_W)) u_sum (
        .chan_i (chan_i),
        .tow_o  (tow_sum)
    );

    ttf_window #(.N_TAP(N_TAP), .N_TAP_ALT(N_TAP_ALT), .TOW_W(TOW_W), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .tow_i    (tow_sum),
        .mode_i   (mode),
        .win_o    (win),
        .win_ok_o (win_ok)
    );

    ttf_mac #(.N_TAP(N_TAP), .N_TAP_ALT(N_TAP_ALT), .TOW_W(TOW_W), .COEF_W(COEF_W),
              .PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_i    (win),
        .coef_i   (coef_i),
        .mode_i   (mode),
        .win_ok_i (win_ok),
        .acc_o    (acc_q),
        .acc_v_o  (acc_v_q)
    );

    ttf_quant #(.ACC_W(ACC_W), .SH(SH), .OUT_W(OUT_W)) u_quant (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc_q),
        .acc_v_i     (acc_v_q),
        .thr_i       (thr_i),
        .tow_o       (tow_o),
        .tow_valid_o (tow_valid_o)
    );
endmodule

// File: rtl/ttf_chk.sv
// Property checker for the tower filter, bound to the top module. It relates
// the registered weighted sum to the next output, and counts the edges since
// reset to bound when the valid flag may first rise.
module ttf_chk #(
    parameter int ACC_W    = 29,
    parameter int SH       = 12,
    parameter int OUT_W    = 8,
    parameter int MIN_FILL = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [ACC_W-1:0] acc,
    input logic                    acc_v,
    input logic [ACC_W-2:0]        thr,
    input logic [OUT_W-1:0]        tow,
    input logic                    tow_valid
);
    localparam int CW = $clog2(MIN_FILL + 1);
    localparam logic signed [ACC_W-1:0] SAT_LIM = ACC_W'((2**OUT_W) * (2**SH));
    localparam logic [OUT_W-1:0] MAXQ = OUT_W'(2**OUT_W - 1);

    logic [CW-1:0] cnt;

    // Edges since reset, saturating at MIN_FILL.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt != CW'(MIN_FILL))   cnt <= cnt + 1'b1;
    end

    // R5
    neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_v && acc < 0) |=> (tow == '0));

    // R6
    thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_v && acc < $signed({1'b0, thr})) |=> (tow == '0));

    // R7
    out_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_v && acc >= SAT_LIM && acc >= $signed({1'b0, thr})) |=> (tow == MAXQ));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v |=> tow_valid);

    // R8
    invalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_v |=> !tow_valid);

    // R9
    early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < CW'(MIN_FILL)) |-> !tow_valid);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tow_valid |-> (tow == '0));
endmodule

bind trig_tower_filter ttf_chk #(
    .ACC_W    (ACC_W),
    .SH       (FRAC_W + QSH),
    .OUT_W    (OUT_W),
    .MIN_FILL (N_TAP_ALT + 2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc_q),
    .acc_v     (acc_v_q),
    .thr       (thr_i),
    .tow       (tow_o),
    .tow_valid (tow_valid_o)
);

// File: tb/trig_tower_filter_tb.sv
// Self-checking bench: runs sample patterns through both window shapes and
// several weight sets, predicting each output arithmetically from the
// requirements.
module trig_tower_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH   = 5;
    localparam int SAMP_W = 10;
    localparam int N_TAP  = 8;
    localparam int COEF_W = 12;
    localparam int OUT_W  = 8;
    localparam int ACC_W  = 29;
    localparam int LEN    = 40;
    localparam int WATCHDOG = 100000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_CH*SAMP_W-1:0]  chan_i = '0;
    logic                    tap_mode_i = 1'b0;
    logic [N_TAP*COEF_W-1:0] coef_i = '0;
    logic [ACC_W-2:0]        thr_i = '0;
    logic [OUT_W-1:0]        tow_o;
    logic                    tow_valid_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    longint hist [0:LEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_tower_filter u_dut (
        .clk(clk), .rst_n(rst_n), .chan_i(chan_i), .tap_mode_i(tap_mode_i),
        .coef_i(coef_i), .thr_i(thr_i), .tow_o(tow_o), .tow_valid_o(tow_valid_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int samp(int pat, int n, int ch);
        case (pat)
            0: samp = (n == 12 && ch == 2) ? 1000 : 0;
            1: samp = (n * 37 + ch * 101) % 1024;
            2: samp = 1023;
            3: samp = n * 3 + ch;
            default: samp = (n * n * 13 + ch * 7 + 5) % 1024;
        endcase
    endfunction

    task automatic run_case(input bit mode, input int c[8], input int thr,
                            input int pat, input string xtag);
        int ntap;
        ntap = mode ? 5 : 8;
        tap_mode_i = mode;
        for (int k = 0; k < N_TAP; k++) coef_i[k*COEF_W +: COEF_W] = COEF_W'(c[k]);
        thr_i = (ACC_W-1)'(thr);
        rst_n = 1'b0;
        chan_i = '0;
        repeat (2) @(negedge clk);
        // R9: reset state
        checks++;
        if (tow_o !== '0 || tow_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: out=%0d valid=%0b exp=0 valid=0", tow_o, tow_valid_o);
        end
        rst_n = 1'b1;
        for (int n = 1; n <= LEN; n++) begin
            int j;
            longint s;
            int eo;
            bit ev;
            string tag;
            if (n > 1) @(negedge clk);
            j  = n - 3;
            ev = (j >= ntap);
            eo = 0;
            tag = "R9";
            if (ev) begin
                s = 0;
                for (int k = 0; k < ntap; k++) s += longint'(c[k]) * hist[j - (ntap - 1) + k];
                if (s < 0)                tag = "R5";
                else if (s < thr)         tag = "R6";
                else begin
                    eo = int'(s >>> 12);
                    if (eo > 255) begin eo = 255; tag = "R7"; end
                    else tag = mode ? "R3 R7" : "R2 R7";
                end
            end
            checks++;
            if (tow_valid_o !== ev || int'(tow_o) != eo) begin
                errors++;
                $display("FAIL %s R1 R8 %s: pat=%0d mode=%0b n=%0d out=%0d valid=%0b exp=%0d valid=%0b",
                         tag, xtag, pat, mode, n, tow_o, tow_valid_o, eo, ev);
            end
            hist[n] = 0;
            for (int ch = 0; ch < N_CH; ch++) begin
                chan_i[ch*SAMP_W +: SAMP_W] = SAMP_W'(samp(pat, n, ch));
                hist[n] += samp(pat, n, ch);
            end
        end
    endtask

    initial begin
        int wa [8]  = '{-54, -54, -54, -36, 241, 51, -44, -54};
        int w5 [8]  = '{-384, -384, 256, 256, 256, 777, -999, 500};
        int wb [8]  = '{50, 100, 150, 200, 250, 300, 350, 400};
        int wpos[8] = '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047};
        int wneg[8] = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
        // R2: nominal long-window weights over all patterns
        for (int p = 0; p < 5; p++) run_case(1'b0, wa, 410, p, "R2");
        // R3: short window, nonzero unused coefficients
        for (int p = 0; p < 5; p++) run_case(1'b1, w5, 410, p, "R3");
        // R2 R3: distinct positive weights separate taps
        for (int p = 0; p < 5; p++) run_case(1'b0, wb, 410, p, "R2");
        for (int p = 0; p < 5; p++) run_case(1'b1, wb, 410, p, "R3");
        // R6: raised noise cut
        run_case(1'b0, wa, 100000, 1, "R6");
        run_case(1'b0, wb, 3000000, 4, "R6");
        run_case(1'b1, wb, 2000000, 3, "R6");
        // R4: extreme weights at full scale
        run_case(1'b0, wpos, 0, 2, "R4");
        run_case(1'b0, wneg, 0, 2, "R4");
        run_case(1'b1, wneg, 0, 4, "R4");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule